// File: doc/BRIEF.md
# Codec Serial Control Port with Soft Reset

This block is the register-write side of an audio codec's control interface. A host writes 16-bit words over a three-wire serial link made of a bit clock, a data line and an active-low select. Each complete word splits into a 7-bit register address and a 9-bit value, and the value is stored in a small register file. Every serial input is oversampled in the master-clock domain, so the whole block runs on one clock.

Writing zero to the reset register starts a software reset. The reset rises when the select line returns high and falls on the next bit-clock rising edge. While it is active, every register except the reset register holds its default value. One bit of the sampling-control register chooses whether the core runs at the full master-clock rate or at half rate. The choice drives a core-clock enable, so a 512fs master clock can feed a core that works at 256fs.

Top module: `codec_ctrl_port`

## Requirements
- R1: A word is 16 bits, sent MSB first and sampled on bit-clock rising edges while select is low. Bits 15:9 are the address and bits 8:0 are the data. The word is stored when select rises. Addresses 0 to 15 exist. Writes to other addresses change nothing, and reading them returns 0. `rd_data` shows the register at `rd_addr` one clock later.
- R2: A word with fewer or more than 16 bits between the select falling and the select rising writes no register and starts no soft reset.
- R3: Writing data 0 to address 15 (the reset register) raises `sw_rst` after the select rising edge that ends the word.
- R4: An active `sw_rst` falls on the next bit-clock rising edge. This holds even when that edge comes while select is high.
- R5: The reset register keeps its value through a soft reset. Writing it with a nonzero value stores the value and does not start a reset.
- R6: While `sw_rst` is high, every other register reads its default. The defaults are 0x097 for addresses 0 and 1, 0x079 for addresses 2 and 3, 0x00A for address 4, 0x09F for address 6, and 0 for every other address.
- R7: Bit 6 of address 8 is the divide select. Its default is 0, and it reads back as written.
- R8: `core_ce` is high on every clock cycle when the divide select is 0, and on every other cycle when it is 1. A change of the select never produces two low cycles in a row.
- R9: While `rst` is high, every register takes its default value, `sw_rst` is low and `core_ce` is low.
- R10: Bit-clock and data activity while select is high does not write any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock |
| sdin | input | 1 | Serial data in |
| csb | input | 1 | Serial select, active low |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 9 | Registered read data |
| sw_rst | output | 1 | Software reset pulse |
| core_ce | output | 1 | Core clock enable |

## Verification
A serial edge reaches the logic 3 master-clock cycles after the pin changes: 2 synchronizer stages and 1 edge-detect stage. The decoded write pulse adds one more register, and the register file or `sw_rst` changes one cycle after that, so the result is due about 5 cycles after the pin moves. The bench moves the serial pins only every 4 clock cycles. It waits 8 cycles after each select rise or bit-clock rise before it samples, and it samples on the falling clock edge. A read result is sampled two cycles after the address is set, and the clock-enable rate is counted over a 20-cycle window.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 9;
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int NREG     = 16;
  localparam int RST_ADDR = 15;
  localparam int SMP_ADDR = 8;
  localparam int DIV_BIT  = 6;

  function automatic logic [DATA_W-1:0] reg_default(input int a);
    case (a)
      0, 1:    return 9'h097;
      2, 3:    return 9'h079;
      4:       return 9'h00A;
      6:       return 9'h09F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ccp_serial_rx.sv
module ccp_serial_rx #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              csb,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sclk_rise
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  logic [SYNC_STAGES-1:0] sclk_sy, sdin_sy, csb_sy;
  logic sclk_d, csb_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_sy[s] <= 1'b0;
          sdin_sy[s] <= 1'b0;
          csb_sy[s]  <= 1'b1;
        end else if (s == 0) begin
          sclk_sy[s] <= sclk;
          sdin_sy[s] <= sdin;
          csb_sy[s]  <= csb;
        end else begin
          sclk_sy[s] <= sclk_sy[s-1];
          sdin_sy[s] <= sdin_sy[s-1];
          csb_sy[s]  <= csb_sy[s-1];
        end
      end
    end
  endgenerate

  logic sclk_s, sdin_s, csb_s;
  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign sdin_s = sdin_sy[SYNC_STAGES-1];
  assign csb_s  = csb_sy[SYNC_STAGES-1];

  logic sclk_up, csb_up, csb_dn;
  assign sclk_up = sclk_s & ~sclk_d;
  assign csb_up  = csb_s & ~csb_d;
  assign csb_dn  = ~csb_s & csb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      csb_d     <= 1'b1;
      shreg     <= '0;
      cnt       <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sclk_rise <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      csb_d     <= csb_s;
      sclk_rise <= sclk_up;
      if (csb_dn) begin
        cnt <= '0;
      end else if (sclk_up && !csb_s) begin
        shreg <= {shreg[WORD_W-2:0], sdin_s};
        if (cnt <= CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
      end
      wr_valid <= csb_up && (cnt == CNT_W'(WORD_W));
      wr_addr  <= shreg[WORD_W-1:DATA_W];
      wr_data  <= shreg[DATA_W-1:0];
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  a_r10_write_needs_select_rise: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> csb_d);
endmodule

// File: rtl/ccp_regfile.sv
module ccp_regfile
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sclk_rise,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sw_rst,
  output logic              div_sel
);
  localparam int IDX_W = $clog2(NREG);

  logic [NREG-1:0][DATA_W-1:0] q;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      localparam logic [DATA_W-1:0] DEF = reg_default(g);
      logic hit;
      assign hit = wr_valid && (wr_addr == ADDR_W'(g));
      if (g == RST_ADDR) begin : g_keep
        always_ff @(posedge clk) begin
          if (rst)      q[g] <= DEF;
          else if (hit) q[g] <= wr_data;
        end
        a_r5_keep_through_reset: assert property (@(posedge clk) disable iff (rst)
          sw_rst && !hit |=> $stable(q[g]));
      end else begin : g_norm
        always_ff @(posedge clk) begin
          if (rst)         q[g] <= DEF;
          else if (sw_rst) q[g] <= DEF;
          else if (hit)    q[g] <= wr_data;
        end
        a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
          sw_rst |=> (q[g] == DEF));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rst  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (sw_rst && sclk_rise)
        sw_rst <= 1'b0;
      else if (wr_valid && wr_addr == ADDR_W'(RST_ADDR) && wr_data == '0)
        sw_rst <= 1'b1;
      rd_data <= (rd_addr < ADDR_W'(NREG)) ? q[rd_addr[IDX_W-1:0]] : '0;
    end
  end

  assign div_sel = q[SMP_ADDR][DIV_BIT];

  a_r3_trigger: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_addr == ADDR_W'(RST_ADDR) && wr_data == '0 && !sw_rst |=> sw_rst);
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    sw_rst && sclk_rise |=> !sw_rst);
endmodule

// File: rtl/ccp_ce_gen.sv
module ccp_ce_gen (
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  output logic core_ce
);
  logic phase, sel, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      sel     <= 1'b0;
      core_ce <= 1'b0;
    end else begin
      phase   <= ~phase;
      if (phase) sel <= div_sel;
      core_ce <= ~sel | ~phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r8_no_double_gap: assert property (@(posedge clk) disable iff (rst)
    armed && !core_ce |=> core_ce);
  a_r9_ce_low_in_reset: assert property (@(posedge clk)
    rst |=> !core_ce);
endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              csb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sw_rst,
  output logic              core_ce
);
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              sclk_rise;
  logic              div_sel;

  ccp_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) i_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .csb(csb),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .sclk_rise(sclk_rise)
  );

  ccp_regfile i_regs (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .sclk_rise(sclk_rise), .rd_addr(rd_addr),
    .rd_data(rd_data), .sw_rst(sw_rst), .div_sel(div_sel)
  );

  ccp_ce_gen i_ce (
    .clk(clk), .rst(rst), .div_sel(div_sel), .core_ce(core_ce)
  );
endmodule

// File: tb/test_codec_ctrl_port.sv
module test_codec_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  localparam logic [24:0] VEC [NVEC] = '{
    {7'd0,  9'h1AB, 9'h1AB},
    {7'd5,  9'h155, 9'h155},
    {7'd8,  9'h040, 9'h040},
    {7'd15, 9'h001, 9'h001},
    {7'd20, 9'h1FF, 9'h000},
    {7'd3,  9'h000, 9'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdin = 1'b0, csb = 1'b1;
  logic [6:0] rd_addr = '0;
  logic [8:0] rd_data;
  logic sw_rst, core_ce;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctrl_port i_codec_ctrl_port (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .csb(csb),
    .rd_addr(rd_addr), .rd_data(rd_data), .sw_rst(sw_rst), .core_ce(core_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    csb = 1'b0;
    wait_cycles(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      wait_cycles(HALF);
      sclk = 1'b1;
      wait_cycles(HALF);
      sclk = 1'b0;
    end
    wait_cycles(HALF);
    csb = 1'b1;
    wait_cycles(8);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    wait_cycles(HALF);
    sclk = 1'b0;
    wait_cycles(8);
  endtask

  task automatic read(input int a, output int v);
    rd_addr = 7'(a);
    wait_cycles(2);
    v = int'(rd_data);
  endtask

  task automatic count_ce(output int c);
    c = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_ce) c++;
    end
  endtask

  initial begin
    int v, c;
    wait_cycles(1);
    check("R9 core_ce low in reset", int'(core_ce), 0);
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(4);
    check("R9 sw_rst low after reset", int'(sw_rst), 0);
    read(0, v);  check("R9 default addr0", v, 'h097);
    read(6, v);  check("R9 default addr6", v, 'h09F);
    read(8, v);  check("R7 divide select default", v, 0);
    count_ce(c); check("R8 full rate", c, 20);

    for (int k = 0; k < NVEC; k++) begin
      send({16'd0, VEC[k][24:9]}, 16);
      read(int'(VEC[k][24:18]), v);
      check("R1 write/readback", v, int'(VEC[k][8:0]));
    end
    check("R5 nonzero reset write no pulse", int'(sw_rst), 0);
    count_ce(c); check("R8 half rate", c, 10);

    send({16'd0, 7'd0, 9'h055} >> 1, 15);
    read(0, v);  check("R2 short word discarded", v, 'h1AB);
    send({15'd0, 7'd15, 9'h000, 1'b0}, 17);
    check("R2 long reset word no pulse", int'(sw_rst), 0);
    read(15, v); check("R2 long word no write", v, 'h001);

    csb = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sdin = i[0];
      wait_cycles(HALF);
      sclk = ~sclk;
    end
    sclk = 1'b0;
    wait_cycles(8);
    read(5, v);  check("R10 idle activity ignored", v, 'h155);

    send({16'd0, 7'd15, 9'h000}, 16);
    check("R3 soft reset asserted", int'(sw_rst), 1);
    read(0, v);  check("R6 addr0 default during reset", v, 'h097);
    read(5, v);  check("R6 addr5 default during reset", v, 0);
    read(8, v);  check("R6 divide select cleared", v, 0);
    read(15, v); check("R5 reset register keeps value", v, 0);
    count_ce(c); check("R8 full rate during soft reset", c, 20);
    check("R4 reset held until bit clock", int'(sw_rst), 1);
    sclk_pulse();
    check("R4 soft reset released", int'(sw_rst), 0);
    read(0, v);  check("R6 default kept after release", v, 'h097);

    send({16'd0, 7'd8, 9'h040}, 16);
    count_ce(c); check("R8 half rate again", c, 10);
    send({16'd0, 7'd8, 9'h000}, 16);
    count_ce(c); check("R8 back to full rate", c, 20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule